// File: doc/BRIEF.md
# Quadrature Phase-Counting Timer Channel

This block is a single 16-bit timer channel. In normal mode it counts up from the system clock through a power-of-two prescaler. In phase-counting mode it takes its count clock from two external phase signals, A and B, and from nothing else. It counts every edge of either input (×4 resolution) and takes the direction from which input leads. The compare/capture register, the counter clear on a match and the interrupt enables work the same way in both modes. Overflow, underflow and the live count direction are reported as separate flags.

Software drives the block through a small write port with four registers:

| Address | Register | Contents |
|---|---|---|
| 0 | CTRL | mode, run, clear source, capture select, prescale |
| 1 | IEN | interrupt enables |
| 2 | STAT | flag clearing |
| 3 | GR | compare value |

The counter, the compare/capture register and the flags are visible directly on output ports.

Setup takes two steps: select the mode in CTRL, then set the run bit. The phase inputs and the capture input each pass through a two-flop synchronizer. The phase decoder is a four-state machine whose states are the sampled level pairs {A,B}: `PH_00`, `PH_10`, `PH_11` and `PH_01`. From each state there are four kinds of transition:
- **forward**: to the next state in the order 00→10→11→01→00. This is a count-up event.
- **backward**: to the previous state in that order. This is a count-down event.
- **hold**: the same state. This gives no event.
- **diagonal**: both inputs changed in one sample. This is an invalid event. The state moves, but no count is made.

Top module: `qpc_timer`

## Requirements
- R1: After reset the counter is 0, GR is 0xFFFF, all three flags are 0, the direction flag is 1 and the interrupt request is 0.
- R2: With CTRL[0]=0 (normal mode) and CTRL[1]=1, the counter increments once every 2^P clocks, where P is CTRL[6:5].
- R3: With CTRL[0]=1, each forward transition of {A,B} (00→10→11→01→00, A leading) adds one to the counter. Each backward transition subtracts one. The prescale field has no effect in this mode.
- R4: A sample in which A and B both changed leaves the counter unchanged.
- R5: The counter changes only while CTRL[1]=1; clearing that bit holds the count. Input events received while it is 0 are lost. A capture clear is the one exception.
- R6: An up count from 0xFFFF to 0x0000 sets the sticky overflow flag.
- R7: A down count from 0x0000 to 0xFFFF sets the sticky underflow flag.
- R8: The direction flag is 1 after a forward transition and 0 after a backward one. It is held at 1 in normal mode.
- R9: With CTRL[4]=0, a count event that moves the counter onto the GR value sets the match flag. With the clear field CTRL[3:2]=01, the next count event loads 0 instead of stepping, and it sets neither overflow nor underflow.
- R10: With CTRL[4]=1, a rising edge on the synchronized capture input copies the counter into GR and sets the match flag. With CTRL[3:2]=10, the counter is also loaded with 0 on that edge.
- R11: A write to STAT (address 2) clears each flag whose bit is written 0: bit 0 is overflow, bit 1 is underflow and bit 2 is match. A bit written 1 leaves its flag unchanged. A hardware set in the same cycle wins over the clear.
- R12: The interrupt request is high exactly when some flag is set and its enable bit in IEN (address 1, same bit positions as STAT) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 CTRL, 1 IEN, 2 STAT, 3 GR |
| wr_data | input | 16 | Write data |
| ph_a | input | 1 | Phase A input, asynchronous |
| ph_b | input | 1 | Phase B input, asynchronous |
| cap_in | input | 1 | Capture input, asynchronous, active on its rising edge |
| count_o | output | 16 | Counter value |
| gr_o | output | 16 | Compare/capture register value |
| ovf_o | output | 1 | Overflow flag |
| unf_o | output | 1 | Underflow flag |
| match_o | output | 1 | Compare match / capture flag |
| dir_up_o | output | 1 | Count direction, 1 means up |
| irq_o | output | 1 | Interrupt request |

## Verification
The phase decoder is driven with four patterns:
- A full forward cycle, which must give +4 and the up direction.
- The same cycle backward, which must give −4 and the down direction. Between them, these two patterns tell a ×4 decoder apart from a ×1 or ×2 decoder and show whether the A-leads rule is inverted.
- Diagonal jumps, which tell invalid samples apart from real edges.
- Steps with the run bit clear, which show that events are gated rather than queued.

A single backward step from zero followed by a forward step checks the wrap flags and confirms that underflow and overflow are kept separate. Normal mode is run with two prescale settings over fixed windows, so that a wrong divide ratio shows up as a different count.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    // Decoder states, encoded as the sampled level pair {A,B}
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_10 = 2'b10,
        PH_11 = 2'b11,
        PH_01 = 2'b01
    } ph_state_t;

    // Counter clear source
    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_CMP  = 2'b01,
        CLR_CAP  = 2'b10,
        CLR_RSV  = 2'b11
    } clr_sel_t;

    typedef struct packed {
        logic match;
        logic unf;
        logic ovf;
    } flags_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_IEN  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam logic [1:0] ADDR_GR   = 2'd3;

    localparam int CTRL_MODE_BIT = 0;
    localparam int CTRL_RUN_BIT  = 1;
    localparam int CTRL_CLR_LSB  = 2;
    localparam int CTRL_CAP_BIT  = 4;
    localparam int CTRL_PSC_LSB  = 5;

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/qpc_decoder.sv
module qpc_decoder
    import qpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    input  logic b_i,
    output logic up_o,
    output logic dn_o
);

    ph_state_t st_q;
    ph_state_t st_n;

    assign st_n = ph_state_t'({a_i, b_i});

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PH_00;
        end else begin
            st_q <= st_n;
        end
    end

    // Outputs: forward = up, backward = down, hold/diagonal = none
    always_comb begin
        up_o = 1'b0;
        dn_o = 1'b0;
        unique case (st_q)
            PH_00: begin
                if (st_n == PH_10)      up_o = 1'b1;
                else if (st_n == PH_01) dn_o = 1'b1;
            end
            PH_10: begin
                if (st_n == PH_11)      up_o = 1'b1;
                else if (st_n == PH_00) dn_o = 1'b1;
            end
            PH_11: begin
                if (st_n == PH_01)      up_o = 1'b1;
                else if (st_n == PH_10) dn_o = 1'b1;
            end
            PH_01: begin
                if (st_n == PH_00)      up_o = 1'b1;
                else if (st_n == PH_11) dn_o = 1'b1;
            end
        endcase
    end

    // R3
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({up_o, dn_o}));

endmodule

// File: rtl/qpc_counter.sv
module qpc_counter
    import qpc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_phase,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    input  clr_sel_t         clr_sel,
    input  logic             cap_mode,
    input  logic             gr_wr,
    input  logic [CNT_W-1:0] gr_wdata,
    input  logic             up_evt,
    input  logic             dn_evt,
    input  logic             cap_edge,
    input  flags_t           flag_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] gr_o,
    output flags_t           flags_o,
    output logic             dir_up_o
);

    localparam int               PRE_W   = (1 << PSC_W) - 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_mask;
    logic [CNT_W-1:0] cnt_q, gr_q, cnt_step;
    flags_t           flags_q;
    logic             dir_q;
    logic             tick, evt, going_up, cmp_clear, cap_clear;
    logic             ovf_set, unf_set, match_set;

    assign pre_mask = PRE_W'((1 << psc) - 1);
    assign tick     = ((pre_q & pre_mask) == pre_mask);
    assign evt      = run && (mode_phase ? (up_evt || dn_evt) : tick);
    assign going_up = mode_phase ? up_evt : 1'b1;
    assign cnt_step = going_up ? cnt_q + 1'b1 : cnt_q - 1'b1;

    assign cmp_clear = evt && !cap_mode && (cnt_q == gr_q) && (clr_sel == CLR_CMP);
    assign cap_clear = cap_mode && cap_edge && (clr_sel == CLR_CAP);

    assign ovf_set   = evt && !cmp_clear && !cap_clear && going_up && (cnt_q == CNT_MAX);
    assign unf_set   = evt && !cmp_clear && !cap_clear && !going_up && (cnt_q == '0);
    assign match_set = (evt && !cap_mode && !cmp_clear && (cnt_step == gr_q))
                     || (cap_mode && cap_edge);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (run && !mode_phase) begin
            pre_q <= pre_q + 1'b1;
        end else begin
            pre_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cap_clear || cmp_clear) begin
            cnt_q <= '0;
        end else if (evt) begin
            cnt_q <= cnt_step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gr_q <= CNT_MAX;
        end else if (cap_mode && cap_edge) begin
            gr_q <= cnt_q;
        end else if (gr_wr) begin
            gr_q <= gr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= 1'b1;
        end else if (!mode_phase) begin
            dir_q <= 1'b1;
        end else if (up_evt) begin
            dir_q <= 1'b1;
        end else if (dn_evt) begin
            dir_q <= 1'b0;
        end
    end

    // Hardware set wins over a software clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q.ovf   <= ovf_set   | (flags_q.ovf   & ~flag_clr.ovf);
            flags_q.unf   <= unf_set   | (flags_q.unf   & ~flag_clr.unf);
            flags_q.match <= match_set | (flags_q.match & ~flag_clr.match);
        end
    end

    assign cnt_o    = cnt_q;
    assign gr_o     = gr_q;
    assign flags_o  = flags_q;
    assign dir_up_o = dir_q;

    // R6
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q.ovf) |-> ($past(cnt_q) == CNT_MAX && cnt_q == '0));

    // R7
    unf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q.unf) |-> ($past(cnt_q) == '0 && cnt_q == CNT_MAX));

    // R5
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cap_clear) |=> $stable(cnt_q));

    // R8
    dir_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_phase |=> dir_q);

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_set && flag_clr.ovf) |=> flags_q.ovf);

endmodule

// File: rtl/qpc_timer.sv
module qpc_timer
    import qpc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PSC_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ph_a,
    input  logic             ph_b,
    input  logic             cap_in,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] gr_o,
    output logic             ovf_o,
    output logic             unf_o,
    output logic             match_o,
    output logic             dir_up_o,
    output logic             irq_o
);

    localparam int CTRL_USED = CTRL_PSC_LSB + PSC_W;

    logic             mode_q, run_q, cap_mode_q;
    clr_sel_t         clr_sel_q;
    logic [PSC_W-1:0] psc_q;
    flags_t           ien_q, flag_clr, flags;
    logic [2:0]       sync_q;
    logic             cap_prev_q, cap_edge, up_evt, dn_evt, gr_wr;
    logic             unused_wdata;

    assign unused_wdata = ^wr_data[CNT_W-1:CTRL_USED];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= 1'b0;
            run_q      <= 1'b0;
            cap_mode_q <= 1'b0;
            clr_sel_q  <= CLR_NONE;
            psc_q      <= '0;
            ien_q      <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL) begin
                mode_q     <= wr_data[CTRL_MODE_BIT];
                run_q      <= wr_data[CTRL_RUN_BIT];
                clr_sel_q  <= clr_sel_t'(wr_data[CTRL_CLR_LSB +: 2]);
                cap_mode_q <= wr_data[CTRL_CAP_BIT];
                psc_q      <= wr_data[CTRL_PSC_LSB +: PSC_W];
            end else if (wr_addr == ADDR_IEN) begin
                ien_q <= flags_t'(wr_data[2:0]);
            end
        end
    end

    assign flag_clr = (wr_en && wr_addr == ADDR_STAT) ? flags_t'(~wr_data[2:0]) : flags_t'(3'b000);
    assign gr_wr    = wr_en && (wr_addr == ADDR_GR);

    qpc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cap_in, ph_a, ph_b}),
        .q_o   (sync_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_prev_q <= 1'b0;
        else        cap_prev_q <= sync_q[2];
    end

    assign cap_edge = sync_q[2] & ~cap_prev_q;

    qpc_decoder u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (sync_q[1]),
        .b_i   (sync_q[0]),
        .up_o  (up_evt),
        .dn_o  (dn_evt)
    );

    qpc_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_phase (mode_q),
        .run        (run_q),
        .psc        (psc_q),
        .clr_sel    (clr_sel_q),
        .cap_mode   (cap_mode_q),
        .gr_wr      (gr_wr),
        .gr_wdata   (wr_data),
        .up_evt     (up_evt),
        .dn_evt     (dn_evt),
        .cap_edge   (cap_edge),
        .flag_clr   (flag_clr),
        .cnt_o      (count_o),
        .gr_o       (gr_o),
        .flags_o    (flags),
        .dir_up_o   (dir_up_o)
    );

    assign ovf_o   = flags.ovf;
    assign unf_o   = flags.unf;
    assign match_o = flags.match;
    assign irq_o   = |(flags & ien_q);

    // R12
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == flags_t'(3'b000)) |-> !irq_o);

    // R12
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags != flags_t'(3'b000)));

endmodule

// File: tb/qpc_timer_bench.sv
module qpc_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic        ph_a = 1'b0, ph_b = 1'b0, cap_in = 1'b0;
    logic [15:0] count_o, gr_o;
    logic        ovf_o, unf_o, match_o, dir_up_o, irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    qpc_timer u_qpc_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ph_a(ph_a), .ph_b(ph_b), .cap_in(cap_in),
        .count_o(count_o), .gr_o(gr_o), .ovf_o(ovf_o), .unf_o(unf_o),
        .match_o(match_o), .dir_up_o(dir_up_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; ph_a = 1'b0; ph_b = 1'b0; cap_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input logic a, input logic b);
        @(negedge clk);
        ph_a = a; ph_b = b;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 count", count_o, 0);
        chk("R1 gr", gr_o, 16'hFFFF);
        chk("R1 flags", {ovf_o, unf_o, match_o}, 0);
        chk("R1 dir", dir_up_o, 1);
        chk("R1 irq", irq_o, 0);
    endtask

    task automatic t_normal();
        logic [15:0] c0;
        do_reset();
        wr(2'd0, 16'h0002);
        c0 = count_o;
        repeat (10) @(negedge clk);
        chk("R2 div1", count_o, c0 + 16'd10);
        chk("R8 normal dir", dir_up_o, 1);
        wr(2'd0, 16'h0042);
        c0 = count_o;
        repeat (40) @(negedge clk);
        chk("R2 div4", count_o, c0 + 16'd10);
        wr(2'd0, 16'h0000);
        c0 = count_o;
        repeat (20) @(negedge clk);
        chk("R5 stopped hold", count_o, c0);
    endtask

    task automatic t_phase();
        do_reset();
        wr(2'd0, 16'h0063);
        step(1, 0); step(1, 1); step(0, 1); step(0, 0);
        chk("R3 forward x4", count_o, 4);
        chk("R8 dir up", dir_up_o, 1);
        step(0, 1);
        chk("R3 backward one", count_o, 3);
        chk("R8 dir down", dir_up_o, 0);
        step(1, 1); step(1, 0); step(0, 0);
        chk("R3 backward x4", count_o, 0);
    endtask

    task automatic t_invalid();
        do_reset();
        wr(2'd0, 16'h0003);
        step(1, 1);
        chk("R4 diagonal from 00", count_o, 0);
        step(0, 1);
        chk("R4 valid after diagonal", count_o, 1);
        step(1, 0);
        chk("R4 diagonal from 01", count_o, 1);
    endtask

    task automatic t_run_gate();
        do_reset();
        wr(2'd0, 16'h0001);
        step(1, 0);
        chk("R5 no count when stopped", count_o, 0);
        wr(2'd0, 16'h0003);
        step(1, 1);
        chk("R5 count after start", count_o, 1);
    endtask

    task automatic t_wrap();
        do_reset();
        wr(2'd0, 16'h0003);
        step(0, 1);
        chk("R7 underflow value", count_o, 16'hFFFF);
        chk("R7 underflow flag", unf_o, 1);
        chk("R6 no overflow on down", ovf_o, 0);
        step(0, 0);
        chk("R6 overflow value", count_o, 0);
        chk("R6 overflow flag", ovf_o, 1);
        chk("R7 underflow sticky", unf_o, 1);
        wr(2'd2, 16'h0006);
        chk("R11 ovf cleared", ovf_o, 0);
        chk("R11 unf kept", unf_o, 1);
        chk("R12 irq masked", irq_o, 0);
        wr(2'd1, 16'h0002);
        chk("R12 irq enabled", irq_o, 1);
    endtask

    task automatic t_compare();
        do_reset();
        wr(2'd3, 16'd3);
        wr(2'd1, 16'h0004);
        wr(2'd0, 16'h0007);
        step(1, 0); step(1, 1);
        chk("R9 no early match", match_o, 0);
        step(0, 1);
        chk("R9 match count", count_o, 3);
        chk("R9 match flag", match_o, 1);
        chk("R12 irq on match", irq_o, 1);
        step(0, 0);
        chk("R9 clear on next event", count_o, 0);
        chk("R9 no overflow on clear", ovf_o, 0);
        wr(2'd2, 16'h0003);
        chk("R11 match cleared", match_o, 0);
        chk("R12 irq drops", irq_o, 0);
    endtask

    task automatic t_capture();
        do_reset();
        wr(2'd0, 16'h0003);
        step(1, 0); step(1, 1); step(0, 1);
        wr(2'd0, 16'h001B);
        @(negedge clk);
        cap_in = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 captured value", gr_o, 3);
        chk("R10 capture clear", count_o, 0);
        chk("R10 capture flag", match_o, 1);
        cap_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_phase();
        t_invalid();
        t_run_gate();
        t_wrap();
        t_compare();
        t_capture();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule